// File: doc/BRIEF.md
# Turbo Soft-Value Conditioning Unit

This unit prepares the soft values that circulate in an iterative turbo decoder. It uses only shifts, additions and saturation, with no multiplier. Soft values are 6-bit two's-complement numbers with 2 fractional bits by default.

The channel path applies a reliability weight to each received sample and saturates the result to the internal format. The weight is limited to powers of two and is given as a signed shift amount. A setting of 1 (weight 2) is the nominal operating point. Settings of 0 and 2 give weights 1 and 4, which model a 3 dB error in either direction. Each step of the shift moves the operating point by 3 dB.

The exchange path runs on the same cycle. It takes the component decoder's soft output and removes the received systematic part and the a-priori part, which leaves the decoder's own contribution. It weights that value by 0.75, formed as x minus x shifted right by two, saturates it and passes it to the other component decoder. On the last iteration a flag bypasses this path: the soft output goes out unchanged as the decoded result. Its sign is the bit decision and its magnitude is the confidence. Both results are registered with one cycle of latency under a valid strobe.

Top module: `soft_cond_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `out_valid` is 0.
- R2: `out_valid` equals the value of `in_valid` from the previous clock cycle, so each result appears exactly one cycle after its inputs.
- R3: For a shift setting s > 0, `chan_out` is `chan_in` multiplied by 2^s, saturated to the range [-32, 31].
- R4: For a shift setting s < 0 (two's complement in `lc_shift`), `chan_out` is `chan_in` divided by 2^-s and rounded toward negative infinity, which is an arithmetic right shift.
- R5: Shift settings 0, 1 and 2 multiply the channel sample by exactly 1, 2 and 4 (with saturation), and a shift never changes the sign of a sample.
- R6: With `final_it` = 0, the extrinsic value is e = `llr_in` − `sys_in` − `apri_in`, computed at full width with no intermediate wrap.
- R7: With `final_it` = 0, `exch_out` is e − floor(e/4), sign-extended to the output width.
- R8: With `final_it` = 0, the weighted extrinsic value is saturated to the 6-bit range [-32, 31] before it is output.
- R9: With `final_it` = 1, `exch_out` equals `llr_in` bit for bit, with no subtraction, weighting or saturation.
- R10: When `in_valid` is 0, `chan_out` and `exch_out` keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| chan_in | input | 6 | Received channel sample, signed |
| lc_shift | input | 3 | Reliability shift amount, signed, range -4..3 |
| llr_in | input | 8 | Component decoder soft output, signed |
| sys_in | input | 6 | Systematic soft value, signed |
| apri_in | input | 6 | A-priori soft value, signed |
| final_it | input | 1 | 1 selects the unscaled soft output bypass |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| chan_out | output | 6 | Weighted, saturated channel value |
| exch_out | output | 8 | Weighted extrinsic value, or raw soft output on the final iteration |

## Verification
The channel path is driven with every 6-bit sample at every one of the eight shift settings. This separates correct left-shift saturation, right-shift rounding toward negative infinity and the identity setting, and it also shows that sign is kept in every case. The exchange path is driven with every 8-bit soft output against systematic and a-priori values that include both extremes and zero. Some of these combinations fall inside the 6-bit range and others go past it, so the 0.75 weighting with floor rounding can be told apart from saturation. A final-iteration sweep shows the bypass is bit-exact. Cycles with the strobe low and the inputs changed show that the registers hold.

// File: rtl/soft_cond_pkg.sv
package soft_cond_pkg;
  localparam int SOFT_W  = 6;  // internal soft word width
  localparam int FRAC_W  = 2;  // fractional bits of the soft word
  localparam int LLR_W   = 8;  // width of the component decoder soft output
  localparam int SHIFT_W = 3;  // signed reliability shift width

  typedef enum logic {PATH_EXTRINSIC = 1'b0, PATH_BYPASS = 1'b1} exch_sel_e;
endpackage

// File: rtl/soft_sat.sv
module soft_sat #(
  parameter int IW = 10,
  parameter int OW = 6
) (
  input  logic signed [IW-1:0] d,
  output logic signed [OW-1:0] q
);
  generate
    if (IW > OW) begin : g_clip
      localparam logic signed [IW-1:0] HI = IW'((2 ** (OW - 1)) - 1);
      localparam logic signed [IW-1:0] LO = -HI - IW'(1);
      always_comb begin
        if (d > HI)      q = HI[OW-1:0];
        else if (d < LO) q = LO[OW-1:0];
        else             q = d[OW-1:0];
      end
    end else begin : g_ext
      assign q = OW'(d);
    end
  endgenerate
endmodule

// File: rtl/soft_pow2_scaler.sv
module soft_pow2_scaler #(
  parameter int CW = 6,
  parameter int SW = 3,
  parameter int OW = 6
) (
  input  logic signed [CW-1:0] x,
  input  logic signed [SW-1:0] s,
  output logic signed [OW-1:0] y
);
  localparam int SMAX = (2 ** (SW - 1)) - 1;
  localparam int XW   = CW + SMAX + 1;

  logic signed [XW-1:0] wide;
  logic signed [XW-1:0] shifted;
  logic        [SW-1:0] ramt;
  logic        [SW-2:0] lamt;

  always_comb begin
    wide = {{(XW - CW){x[CW-1]}}, x};
    lamt = s[SW-2:0];
    ramt = SW'(~s + SW'(1));
    if (s[SW-1]) shifted = wide >>> ramt;   // factor below one: floor division
    else         shifted = wide <<< lamt;   // factor one or above
  end

  soft_sat #(.IW(XW), .OW(OW)) u_sat (.d(shifted), .q(y));
endmodule

// File: rtl/soft_ext_weight.sv
module soft_ext_weight #(
  parameter int LW = 8,
  parameter int W  = 6
) (
  input  logic signed [LW-1:0] llr,
  input  logic signed [W-1:0]  sys,
  input  logic signed [W-1:0]  apri,
  output logic signed [W-1:0]  ext
);
  localparam int EW = LW + 2;

  logic signed [EW-1:0] own;
  logic signed [EW-1:0] weighted;

  always_comb begin
    own      = EW'(llr) - EW'(sys) - EW'(apri);
    weighted = own - (own >>> 2);            // 0.75 * own, floor rounding
  end

  soft_sat #(.IW(EW), .OW(W)) u_sat (.d(weighted), .q(ext));
endmodule

// File: rtl/soft_cond_unit.sv
module soft_cond_unit
  import soft_cond_pkg::*;
#(
  parameter int W  = SOFT_W,
  parameter int CW = SOFT_W,
  parameter int LW = LLR_W,
  parameter int SW = SHIFT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [CW-1:0] chan_in,
  input  logic signed [SW-1:0] lc_shift,
  input  logic signed [LW-1:0] llr_in,
  input  logic signed [W-1:0]  sys_in,
  input  logic signed [W-1:0]  apri_in,
  input  logic                 final_it,
  output logic                 out_valid,
  output logic signed [W-1:0]  chan_out,
  output logic signed [LW-1:0] exch_out
);
  localparam logic signed [LW-1:0] EXT_HI = LW'((2 ** (W - 1)) - 1);
  localparam logic signed [LW-1:0] EXT_LO = -EXT_HI - LW'(1);

  logic signed [W-1:0]  chan_w;
  logic signed [W-1:0]  ext_w;
  exch_sel_e            sel;
  logic signed [LW-1:0] exch_d;
  logic                 final_q;

  soft_pow2_scaler #(.CW(CW), .SW(SW), .OW(W)) u_chan (
    .x(chan_in), .s(lc_shift), .y(chan_w)
  );

  soft_ext_weight #(.LW(LW), .W(W)) u_ext (
    .llr(llr_in), .sys(sys_in), .apri(apri_in), .ext(ext_w)
  );

  always_comb begin
    sel = final_it ? PATH_BYPASS : PATH_EXTRINSIC;
    if (sel == PATH_BYPASS) exch_d = llr_in;
    else                    exch_d = LW'(ext_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      chan_out  <= '0;
      exch_out  <= '0;
      final_q   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        chan_out <= chan_w;
        exch_out <= exch_d;
        final_q  <= final_it;
      end
    end
  end

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(chan_out) && $stable(exch_out)));

  a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (chan_out[W-1] == $past(chan_in[CW-1])));

  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && final_it) |=> (exch_out == $past(llr_in)));

  a_r8_ext_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !final_q) |-> (exch_out <= EXT_HI && exch_out >= EXT_LO));
endmodule

// File: tb/soft_cond_unit_tb.sv
module soft_cond_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [5:0] chan_in;
  logic signed [2:0] lc_shift;
  logic signed [7:0] llr_in;
  logic signed [5:0] sys_in;
  logic signed [5:0] apri_in;
  logic              final_it;
  logic              out_valid;
  logic signed [5:0] chan_out;
  logic signed [7:0] exch_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  soft_cond_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chan_in(chan_in),
    .lc_shift(lc_shift), .llr_in(llr_in), .sys_in(sys_in), .apri_in(apri_in),
    .final_it(final_it), .out_valid(out_valid), .chan_out(chan_out),
    .exch_out(exch_out)
  );

  function automatic int sat6(input int v);
    if (v > 31)  return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic int exp_chan(input int x, input int s);
    int v;
    if (s >= 0) v = x * (2 ** s);
    else        v = x >>> (-s);
    return sat6(v);
  endfunction

  function automatic int raw_ext(input int l, input int sy, input int ap);
    int e;
    e = l - sy - ap;
    return e - (e >>> 2);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs are applied at a falling edge; the result is read at the next one.
  task automatic apply(input int x, input int s, input int l, input int sy,
                       input int ap, input bit fin);
    in_valid = 1'b1;
    chan_in  = 6'(x);
    lc_shift = 3'(s);
    llr_in   = 8'(l);
    sys_in   = 6'(sy);
    apri_in  = 6'(ap);
    final_it = fin;
    @(negedge clk);
  endtask

  initial begin
    int sys_set[5]  = '{-32, -1, 0, 5, 31};
    int apri_set[4] = '{-32, 0, 7, 31};
    rst_n = 1'b0; in_valid = 1'b0; chan_in = '0; lc_shift = '0;
    llr_in = '0; sys_in = '0; apri_in = '0; final_it = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    check("R1 reset out_valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", int'(out_valid), 0);

    // channel sweep: every sample at every shift
    for (int s = -4; s <= 3; s++) begin
      for (int x = -32; x <= 31; x++) begin
        apply(x, s, 0, 0, 0, 1'b0);
        check("R2 out_valid", int'(out_valid), 1);
        if (s < 0)       check("R4 chan right shift", int'(chan_out), exp_chan(x, s));
        else if (s == 0) check("R5 chan unity", int'(chan_out), exp_chan(x, s));
        else             check("R3 chan left shift", int'(chan_out), exp_chan(x, s));
        if (s == 1 || s == 2) check("R5 nominal and mismatch factor", int'(chan_out), sat6(x * (2 ** s)));
      end
    end

    // extrinsic sweep
    for (int si = 0; si < 5; si++) begin
      for (int ai = 0; ai < 4; ai++) begin
        for (int l = -128; l <= 127; l++) begin
          int r;
          apply(0, 0, l, sys_set[si], apri_set[ai], 1'b0);
          r = raw_ext(l, sys_set[si], apri_set[ai]);
          if (r > 31 || r < -32) check("R8 extrinsic saturation", int'(exch_out), sat6(r));
          else                   check("R6 R7 extrinsic weight", int'(exch_out), r);
        end
      end
    end

    // final iteration bypass
    for (int l = -128; l <= 127; l++) begin
      apply(17, 2, l, 31, -32, 1'b1);
      check("R9 bypass", int'(exch_out), l);
    end

    // hold while strobe is low
    apply(-5, 1, 40, 3, 2, 1'b0);
    in_valid = 1'b0; chan_in = 6'sd21; lc_shift = 3'sd3; llr_in = -8'sd99;
    sys_in = 6'sd1; apri_in = 6'sd1; final_it = 1'b1;
    @(negedge clk);
    check("R2 out_valid low", int'(out_valid), 0);
    check("R10 chan hold", int'(chan_out), -10);
    check("R10 exch hold", int'(exch_out), raw_ext(40, 3, 2));
    @(negedge clk);
    check("R10 chan hold 2", int'(chan_out), -10);
    check("R10 exch hold 2", int'(exch_out), raw_ext(40, 3, 2));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule